// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches three external interrupt pins on behalf of a CPU. Each pin is brought into the clock domain through a short synchroniser chain. A per-channel detector then looks for a programmable condition on it. When that condition occurs, a sticky flag is set. A request line goes to the CPU only when three things are all 1: the channel's enable bit, its flag and the global interrupt enable input.

Channels 0 and 1 have four trigger modes: low level, any change, falling edge and rising edge. Channel 2 triggers on edges only, and one polarity bit selects which edge. The pin is observed whatever drives it, so the chip can drive its own pin to raise a software interrupt.

Software reaches the block through a small register port that writes in one cycle and reads combinationally. There is an enable register, a flag register whose bits are cleared by writing 1, and a sense register. The vector unit clears a served flag through an acknowledge input. There is no streaming data path, so every pin is a plain control or status signal and has no handshake.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the enable, flag and sense registers hold 0, every register reads 0 and `irq_req` is 0.
- R2: Register selection by `reg_sel`: 0 is enable, 1 is flag, 2 is sense, and 3 reads 0 and ignores writes. In the enable and flag registers, bit 6 is channel 0, bit 7 is channel 1 and bit 5 is channel 2. Their bits 4..0 read 0 and ignore writes. The sense register keeps channel 0's code in [1:0], channel 1's code in [3:2] and channel 2's polarity in [4]. Its bits 7..5 read 0.
- R3: With sense code 00 on channel 0 or 1, the flag is set on every cycle that the synchronised pin is low. It comes back on the cycle after a clear for as long as the pin stays low.
- R4: With code 01, every change of the synchronised pin sets the flag.
- R5: Code 10 sets the flag on a falling edge only, and code 11 on a rising edge only.
- R6: Channel 2 reacts to edges only. Polarity bit 1 selects the rising edge and 0 the falling edge. A low level alone never sets its flag.
- R7: Each pin passes through SYNC_STAGES flops. With the default of 2, a pin change made between two clock edges shows in the flag register after the third rising edge that follows. A level held for longer than one clock period is always seen. The synchroniser flops and edge history reset to 1.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R9: When `ack_valid` is high, the flag of channel `ack_id` (0, 1 or 2) is cleared. An `ack_id` of 3 clears nothing.
- R10: When a detected event and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R11: `irq_req[i]` equals enable[i] AND flag[i] AND `gie`, combinationally.
- R12: Flags are set by events whatever the value of the enable bits and `gie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 3 | Raw interrupt pins, bit i is channel i |
| gie | input | 1 | Global interrupt enable |
| reg_sel | input | 2 | Register select: 0 enable, 1 flag, 2 sense |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ack_valid | input | 1 | Vector unit serves a channel this cycle |
| ack_id | input | 2 | Channel being served |
| irq_req | output | 3 | Gated request per channel |

## Verification
The bench builds the block with SYNC_STAGES = 2 and DATA_W = 8. These values give the three-edge latency that its cycle-exact model follows, and the 8-bit register layout in which the reserved bits can be probed.

With two stages, a pin pulse of a single cycle can be sampled. This lets random pin toggling exercise an edge, a clear and an acknowledge in the same cycle, which is how the event-wins rule is reached. Directed sequences cover the low-level re-arm, the edge-only channel that ignores a held low, an acknowledge of channel 3, and writes of zeros to the flag register.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_FLAG   = 2'd1,
    SEL_SENSE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // bit position of a channel inside the enable and flag registers
  function automatic int unsigned ch_pos(input int unsigned ch);
    case (ch)
      0:       return 6;
      1:       return 7;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/sense_detect.sv
module sense_detect
  import extint_pkg::*;
#(
  parameter bit EDGE_ONLY = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  sense_e mode,
  input  logic   rise_sel,
  output logic   evt
);
  logic   prev_q;
  sense_e eff_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= smp;
  end

  generate
    if (EDGE_ONLY) begin : g_edge
      assign eff_mode = rise_sel ? SENSE_RISE : SENSE_FALL;
    end else begin : g_full
      assign eff_mode = mode;
    end
  endgenerate

  always_comb begin
    unique case (eff_mode)
      SENSE_LOW:  evt = ~smp;
      SENSE_ANY:  evt = smp ^ prev_q;
      SENSE_FALL: evt = prev_q & ~smp;
      default:    evt = smp & ~prev_q;
    endcase
  end

  // R5
  edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode != SENSE_LOW && smp == prev_q) |-> !evt);

  // R3
  level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!EDGE_ONLY && mode == SENSE_LOW && !smp) |-> evt);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pin_in,
  input  logic              gie,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ack_valid,
  input  logic [1:0]        ack_id,
  output logic [2:0]        irq_req
);
  localparam int SENSE_W = 5;

  logic [NUM_CH-1:0]  smp, evt, clr, en_q, flag_q;
  logic [SENSE_W-1:0] sense_q;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(reg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sense_q <= '0;
    else if (reg_wr && sel == SEL_SENSE) sense_q <= reg_wdata[SENSE_W-1:0];
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int unsigned POS = ch_pos(ch);

      pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in[ch]), .q_out(smp[ch])
      );

      sense_detect #(.EDGE_ONLY(ch == 2)) u_det (
        .clk(clk), .rst_n(rst_n), .smp(smp[ch]),
        .mode(sense_e'(sense_q[(ch%2)*2 +: 2])),
        .rise_sel(sense_q[4]),
        .evt(evt[ch])
      );

      assign clr[ch] = (reg_wr && sel == SEL_FLAG && reg_wdata[POS])
                     || (ack_valid && ack_id == 2'(ch));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q[ch] <= 1'b0;
        else if (evt[ch]) flag_q[ch] <= 1'b1;
        else if (clr[ch]) flag_q[ch] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           en_q[ch] <= 1'b0;
        else if (reg_wr && sel == SEL_ENABLE) en_q[ch] <= reg_wdata[POS];
      end

      assign irq_req[ch] = en_q[ch] & flag_q[ch] & gie;

      // R10
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[ch] |=> flag_q[ch]);

      // R9
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == 2'(ch) && !evt[ch]) |=> !flag_q[ch]);

      // R8
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_FLAG && reg_wdata[POS] && !evt[ch]) |=> !flag_q[ch]);
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_ENABLE: for (int c = 0; c < NUM_CH; c++) reg_rdata[ch_pos(c)] = en_q[c];
      SEL_FLAG:   for (int c = 0; c < NUM_CH; c++) reg_rdata[ch_pos(c)] = flag_q[c];
      SEL_SENSE:  reg_rdata[SENSE_W-1:0] = sense_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
  localparam int SYNC_STAGES = 2;
  localparam int DATA_W      = 8;

  logic       clk = 0, rst_n = 0, gie = 0, reg_wr = 0, ack_valid = 0;
  logic [2:0] pin_in = 3'b111;
  logic [1:0] reg_sel = 0, ack_id = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [2:0] irq_req;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit done = 0;

  extint_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_id(ack_id), .irq_req(irq_req));

  always #5 clk = ~clk;

  // bench model built from the requirements
  logic [2:0] m_s1, m_s2, m_pv, m_en, m_fl;
  logic [4:0] m_sc;

  function automatic int pos(input int c);
    return (c == 0) ? 6 : (c == 1) ? 7 : 5;
  endfunction

  function automatic logic ev(input int c, input logic s, input logic p, input logic [4:0] sc);
    logic [1:0] code;
    code = (c == 2) ? (sc[4] ? 2'b11 : 2'b10) : sc[c*2 +: 2];
    case (code)
      2'b00:   return ~s;
      2'b01:   return s ^ p;
      2'b10:   return p & ~s;
      default: return s & ~p;
    endcase
  endfunction

  function automatic logic [7:0] rd_model(input logic [1:0] sel);
    logic [7:0] r = 0;
    for (int c = 0; c < 3; c++) begin
      if (sel == 0) r[pos(c)] = m_en[c];
      if (sel == 1) r[pos(c)] = m_fl[c];
    end
    if (sel == 2) r[4:0] = m_sc;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 3'b111; m_s2 = 3'b111; m_pv = 3'b111; m_en = 0; m_fl = 0; m_sc = 0;
    end else begin
      logic [2:0] nf, ne;
      logic [4:0] ns;
      nf = m_fl; ne = m_en; ns = m_sc;
      for (int c = 0; c < 3; c++) begin
        if (reg_wr && reg_sel == 1 && reg_wdata[pos(c)]) nf[c] = 0;
        if (ack_valid && ack_id == 2'(c)) nf[c] = 0;
        if (ev(c, m_s2[c], m_pv[c], m_sc)) nf[c] = 1;
        if (reg_wr && reg_sel == 0) ne[c] = reg_wdata[pos(c)];
      end
      if (reg_wr && reg_sel == 2) ns = reg_wdata[4:0];
      m_fl = nf; m_en = ne; m_sc = ns;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string t, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", t, got, exp);
    end
  endtask

  // one cycle: sample at negedge, compare with model, then inputs may change
  task automatic cyc();
    @(negedge clk);
    chk({tag, " irq"}, {5'b0, irq_req}, {5'b0, m_en & m_fl & {3{gie}}});
    chk({tag, " rdata"}, reg_rdata, rd_model(reg_sel));
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    cyc();
    reg_wr = 0;
  endtask

  task automatic peek_flags(input string t, input logic [7:0] exp);
    reg_sel = 1;
    #1 chk(t, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1";
    for (int s = 0; s < 4; s++) begin reg_sel = 2'(s); #1 chk("R1 reset read", reg_rdata, 8'h00); end
    chk("R1 reset irq", {5'b0, irq_req}, 8'h00);

    // R2 layout and reserved bits
    tag = "R2";
    wreg(0, 8'hFF); reg_sel = 0; #1 chk("R2 enable layout", reg_rdata, 8'hE0);
    wreg(2, 8'hFF); reg_sel = 2; #1 chk("R2 sense layout", reg_rdata, 8'h1F);
    wreg(3, 8'hFF); reg_sel = 3; #1 chk("R2 unused select", reg_rdata, 8'h00);

    // R5 rising on ch0 (code 11), R7 latency
    tag = "R5";
    wreg(2, 8'b000_0_10_11); wreg(1, 8'hE0); gie = 1;
    pin_in[0] = 0; repeat (4) cyc();
    peek_flags("R5 falling ignored in rise mode", 8'h00);
    pin_in[0] = 1; cyc(); cyc();
    peek_flags("R7 not yet after two edges", 8'h00);
    cyc(); peek_flags("R7 flag after third edge", 8'h40);
    chk("R11 irq ch0", {5'b0, irq_req}, 8'h01);
    gie = 0; #1 chk("R11 gie gates", {5'b0, irq_req}, 8'h00); gie = 1;

    // R8 write zero no effect, write one clears
    tag = "R8";
    wreg(1, 8'h1F); peek_flags("R8 write zero keeps", 8'h40);
    wreg(1, 8'h40); peek_flags("R8 w1c clears", 8'h00);

    // R3 low level on ch0 re-arms
    tag = "R3";
    wreg(2, 8'b0_10_00); pin_in[0] = 0; repeat (4) cyc();
    wreg(1, 8'h40); peek_flags("R3 level re-sets after clear", 8'h40);
    pin_in[0] = 1; repeat (3) cyc(); wreg(1, 8'h40); cyc();
    peek_flags("R3 stays clear once high", 8'h00);

    // R6 channel 2 ignores held low, polarity bit
    tag = "R6";
    wreg(2, 8'b0_00_00 | 8'h0F); pin_in[2] = 0; repeat (3) cyc();
    wreg(1, 8'hFF); repeat (4) cyc(); peek_flags("R6 held low ignored", 8'h00);
    pin_in[2] = 1; repeat (4) cyc(); peek_flags("R6 rise ignored pol=0", 8'h00);

    // R9 ack_id 3 ignored, ack of ch2
    tag = "R9";
    pin_in[2] = 0; repeat (4) cyc(); peek_flags("R6 falling seen pol=0", 8'h20);
    ack_valid = 1; ack_id = 3; cyc(); ack_valid = 0; peek_flags("R9 id 3 ignored", 8'h20);
    ack_valid = 1; ack_id = 2; cyc(); ack_valid = 0; peek_flags("R9 ack clears", 8'h00);

    // R4 any change on ch1, R12 with enables off, R10 event wins
    tag = "R4";
    wreg(0, 8'h00); gie = 0; wreg(2, 8'b0_01_00 | 8'h03);
    pin_in[1] = 0; cyc(); cyc();
    reg_sel = 1; reg_wdata = 8'h80; reg_wr = 1; ack_valid = 1; ack_id = 1;
    cyc(); reg_wr = 0; ack_valid = 0;
    peek_flags("R10 event wins over clear", 8'h80);
    chk("R12 no irq but flag set", {5'b0, irq_req}, 8'h00);
    wreg(1, 8'h80); pin_in[1] = 1; repeat (4) cyc();
    peek_flags("R4 any change rising", 8'h80);

    // random phase
    tag = "R11 random";
    for (int i = 0; i < 4000; i++) begin
      pin_in    = 3'($urandom);
      gie       = 1'($urandom);
      reg_sel   = 2'($urandom);
      reg_wdata = 8'($urandom);
      reg_wr    = ($urandom % 4) == 0;
      ack_valid = ($urandom % 4) == 0;
      ack_id    = 2'($urandom);
      cyc();
    end
    reg_wr = 0; ack_valid = 0;
    cyc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule